// File: doc/BRIEF.md
# Threshold Offset Register Port

This block stores the two thresholds a dual-clock FIFO uses to raise its near-empty and near-full warnings. Each threshold is `OFS_W` bits wide (default 13, at most 16). Software or a controller programs them through the FIFO's own 9-bit data input while the shared load-select line is held low. Each programming write fills one byte, in a fixed rotation of four steps. The same rotation, clocked by the read clock, returns the stored bytes on the 9-bit data output.

Both thresholds are given as outputs in the write-clock domain. There the near-full comparator uses them directly. A second copy is given in the read-clock domain for the near-empty comparator. The write side moves a complete snapshot of both values into that copy through a request/acknowledge toggle handshake. A comparator on the read side therefore never sees a value that is partly updated. Readback is taken from the read-domain copy.

Top module: `ofs_port`

## Requirements
- R1: A synchronous reset (active-low `rst_n` seen on a clock edge) sets both thresholds to 7 in both domains, returns both step counters to the first step, and clears `rd_byte` to 0.
- R2: A programming write happens on a `wr_clk` rising edge when `load_n` and `wr_en_n` are both 0. Consecutive writes fill, in this order: near-empty bits 7:0, near-empty upper bits, near-full bits 7:0, near-full upper bits. After the fourth write the rotation wraps to the first step.
- R3: A `wr_clk` edge with `load_n`=0 and `wr_en_n`=1, or with `load_n`=1, changes neither threshold and does not advance the write step.
- R4: A low-byte step copies `wr_byte[7:0]` into bits 7:0. A high-byte step copies `wr_byte[OFS_W-9:0]` into bits `OFS_W-1:8`. `wr_byte[8]`, and every high-byte bit above the threshold width, are ignored.
- R5: A read step happens on an `rd_clk` rising edge when `load_n`, `rd_en_a_n` and `rd_en_b_n` are all 0. It registers onto `rd_byte` the byte chosen by the read step, in the same four-step order as R2, and then advances the step with wrap. `rd_byte` is valid after that one edge.
- R6: Unused bit positions read back as 0. `rd_byte[8]` is always 0, and high-byte bits above `OFS_W-9` are 0.
- R7: An `rd_clk` edge on which either read enable is 1, or `load_n` is 1, leaves `rd_byte` and the read step unchanged.
- R8: The write and read step counters are independent. Programming writes do not move the read step, and reads do not move the write step.
- R9: The write-domain outputs take a new value on the programming edge itself. The read-domain outputs take the whole pair of values in one `rd_clk` edge, within 20 read clocks after the last write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, seen in both domains |
| load_n | input | 1 | Low selects the threshold registers instead of the FIFO memory |
| wr_en_n | input | 1 | Active-low write enable |
| wr_byte | input | 9 | Write data bus |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| rd_byte | output | 9 | Registered readback byte |
| ae_ofs_wr | output | OFS_W | Near-empty threshold, write domain |
| af_ofs_wr | output | OFS_W | Near-full threshold, write domain |
| ae_ofs_rd | output | OFS_W | Near-empty threshold, read domain |
| af_ofs_rd | output | OFS_W | Near-full threshold, read domain |

## Verification
On every cycle the assertions check four things. The step counters advance by exactly one step or hold. The thresholds keep their value on every edge that is not a programming write. The snapshot stays frozen while a handshake is in flight. The readback byte holds when reading is disabled and never drives bit 8. Only the directed scenarios can show the actual byte-to-field mapping, the step order and its wrap, the independence of the two counters, and the arrival of the new values in the read domain. Each of these needs a known data value compared against the value expected from the requirements.

// File: rtl/ofs_pkg.sv
// Shared types and byte helpers for the threshold offset port.
// Assumes thresholds of at most 16 bits, carried zero-extended to 16 bits.
package ofs_pkg;

    // Rotation order of the four byte steps (order is behaviour).
    typedef enum logic [1:0] {
        STEP_AE_LO = 2'd0,
        STEP_AE_HI = 2'd1,
        STEP_AF_LO = 2'd2,
        STEP_AF_HI = 2'd3
    } step_t;

    localparam int unsigned EXT_W = 16;

    // Place one byte into the low or high half of a 16-bit value.
    function automatic logic [EXT_W-1:0] merge_byte(input logic [EXT_W-1:0] cur,
                                                    input logic             hi,
                                                    input logic [7:0]       b);
        logic [EXT_W-1:0] r;
        r = cur;
        if (hi) r[15:8] = b;
        else    r[7:0]  = b;
        return r;
    endfunction

    // Select the byte a given step reads back.
    function automatic logic [7:0] pick_byte(input step_t            s,
                                             input logic [EXT_W-1:0] ae,
                                             input logic [EXT_W-1:0] af);
        logic [7:0] r;
        case (s)
            STEP_AE_LO: r = ae[7:0];
            STEP_AE_HI: r = ae[15:8];
            STEP_AF_LO: r = af[7:0];
            default:    r = af[15:8];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ofs_step_ctr.sv
// Four-step rotating byte sequencer.
// Assumes: advance is sampled on the rising clock edge; reset is synchronous.
module ofs_step_ctr
    import ofs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    output step_t step
);

    // Advance one step per qualifying edge, wrapping after the fourth.
    always_ff @(posedge clk) begin
        if (!rst_n)   step <= STEP_AE_LO;
        else if (adv) step <= step_t'(2'(step + 2'd1));
    end

    // R2 / R5: each qualifying edge moves exactly one step, with wrap
    assert_step_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> step == step_t'(2'($past(step) + 2'd1)));

    // R3 / R7: no qualifying edge, no movement
    assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(step));

endmodule

// File: rtl/ofs_wr_bank.sv
// Write-domain threshold registers: load one byte per programming write.
// Assumes OFS_W in 3..16; unused high-byte bits are dropped by truncation.
module ofs_wr_bank
    import ofs_pkg::*;
#(
    parameter int unsigned OFS_W = 13
) (
    input  logic             wr_clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             wr_en_n,
    input  logic [8:0]       wr_byte,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic             prog_en
);

    localparam logic [OFS_W-1:0] DFLT = OFS_W'(7);

    step_t            wstep;
    logic [EXT_W-1:0] ae_ext, af_ext;
    logic [OFS_W-1:0] ae_nxt, af_nxt;
    logic             is_hi;

    assign prog_en = !load_n && !wr_en_n;
    assign is_hi   = (wstep == STEP_AE_HI) || (wstep == STEP_AF_HI);

    ofs_step_ctr u_wstep (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .adv   (prog_en),
        .step  (wstep)
    );

    // Compute the merged value for whichever threshold this step targets.
    always_comb begin
        ae_ext = merge_byte(EXT_W'(ae_ofs), is_hi, wr_byte[7:0]);
        af_ext = merge_byte(EXT_W'(af_ofs), is_hi, wr_byte[7:0]);
        ae_nxt = ae_ofs;
        af_nxt = af_ofs;
        if (wstep == STEP_AE_LO || wstep == STEP_AE_HI) ae_nxt = ae_ext[OFS_W-1:0];
        else                                            af_nxt = af_ext[OFS_W-1:0];
    end

    // Hold the thresholds; update on a programming write.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            ae_ofs <= DFLT;
            af_ofs <= DFLT;
        end else if (prog_en) begin
            ae_ofs <= ae_nxt;
            af_ofs <= af_nxt;
        end
    end

    // R1: reset loads the default threshold
    assert_rst_dflt_R1: assert property (@(posedge wr_clk)
        !rst_n |=> (ae_ofs == DFLT) && (af_ofs == DFLT));

    // R3: no programming write, no threshold change
    assert_idle_hold_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (load_n || wr_en_n) |=> $stable(ae_ofs) && $stable(af_ofs));

endmodule

// File: rtl/ofs_xfer.sv
// Moves a snapshot of both thresholds into the read clock domain with a
// toggle request/acknowledge handshake; the snapshot is frozen while in flight.
// Assumes both clocks run while reset is low.
module ofs_xfer #(
    parameter int unsigned OFS_W = 13
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             changed,
    input  logic [OFS_W-1:0] ae_src,
    input  logic [OFS_W-1:0] af_src,
    output logic [OFS_W-1:0] ae_dst,
    output logic [OFS_W-1:0] af_dst
);

    localparam logic [OFS_W-1:0] DFLT = OFS_W'(7);

    logic             pend, req_q, ack_s1, ack_s2, idle, launch;
    logic [OFS_W-1:0] ae_shd, af_shd;
    logic             req_s1, req_s2, req_s3;

    assign idle   = (req_q == ack_s2);
    assign launch = pend && idle;

    // Remember that a newer value still has to be sent.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= changed || (pend && !launch);
    end

    // Capture the snapshot and toggle the request when the channel is idle.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            ae_shd <= DFLT;
            af_shd <= DFLT;
        end else if (launch) begin
            req_q  <= !req_q;
            ae_shd <= ae_src;
            af_shd <= af_src;
        end
    end

    // Bring the acknowledge back into the write domain.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= req_s3;
            ack_s2 <= ack_s1;
        end
    end

    // Synchronise the request; the third stage doubles as the acknowledge.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
        end else begin
            req_s1 <= req_q;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
        end
    end

    // Load the whole snapshot in one read-clock edge on a request change.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            ae_dst <= DFLT;
            af_dst <= DFLT;
        end else if (req_s2 != req_s3) begin
            ae_dst <= ae_shd;
            af_dst <= af_shd;
        end
    end

    // R9: snapshot never changes while a transfer is outstanding
    assert_shadow_hold_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !idle |=> $stable(ae_shd) && $stable(af_shd));

    // R9: a new request is only raised once the previous one is acknowledged
    assert_req_idle_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !idle |=> $stable(req_q));

endmodule

// File: rtl/ofs_rd_port.sv
// Read-domain readback: returns one stored byte per read step.
// Assumes the thresholds given are already in the read clock domain.
module ofs_rd_port
    import ofs_pkg::*;
#(
    parameter int unsigned OFS_W = 13
) (
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             rd_en_a_n,
    input  logic             rd_en_b_n,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic [8:0]       rd_byte
);

    step_t rstep;
    logic  rd_en;

    assign rd_en = !load_n && !rd_en_a_n && !rd_en_b_n;

    ofs_step_ctr u_rstep (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .adv   (rd_en),
        .step  (rstep)
    );

    // Register the selected byte; bit 8 and bits above the width stay zero.
    always_ff @(posedge rd_clk) begin
        if (!rst_n)     rd_byte <= '0;
        else if (rd_en) rd_byte <= {1'b0, pick_byte(rstep, EXT_W'(ae_ofs), EXT_W'(af_ofs))};
    end

    // R6: the ninth bit never carries threshold data
    assert_top_zero_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_byte[8] == 1'b0);

    // R7: disabled reads leave the output untouched
    assert_rd_hold_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_byte));

endmodule

// File: rtl/ofs_port.sv
// Top of the threshold offset port: write-domain bank, domain transfer and
// read-domain readback. Assumes OFS_W in 3..16 and a reset held across
// several edges of both clocks.
module ofs_port #(
    parameter int unsigned OFS_W = 13
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             wr_en_n,
    input  logic [8:0]       wr_byte,
    input  logic             rd_en_a_n,
    input  logic             rd_en_b_n,
    output logic [8:0]       rd_byte,
    output logic [OFS_W-1:0] ae_ofs_wr,
    output logic [OFS_W-1:0] af_ofs_wr,
    output logic [OFS_W-1:0] ae_ofs_rd,
    output logic [OFS_W-1:0] af_ofs_rd
);

    logic prog_en;

    ofs_wr_bank #(.OFS_W(OFS_W)) u_bank (
        .wr_clk  (wr_clk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .wr_en_n (wr_en_n),
        .wr_byte (wr_byte),
        .ae_ofs  (ae_ofs_wr),
        .af_ofs  (af_ofs_wr),
        .prog_en (prog_en)
    );

    ofs_xfer #(.OFS_W(OFS_W)) u_xfer (
        .wr_clk  (wr_clk),
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .changed (prog_en),
        .ae_src  (ae_ofs_wr),
        .af_src  (af_ofs_wr),
        .ae_dst  (ae_ofs_rd),
        .af_dst  (af_ofs_rd)
    );

    ofs_rd_port #(.OFS_W(OFS_W)) u_rd (
        .rd_clk    (rd_clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .rd_en_a_n (rd_en_a_n),
        .rd_en_b_n (rd_en_b_n),
        .ae_ofs    (ae_ofs_rd),
        .af_ofs    (af_ofs_rd),
        .rd_byte   (rd_byte)
    );

endmodule

// File: tb/tb_ofs_port.sv
// Directed bench for ofs_port at the default 13-bit width.
module tb_ofs_port;

    localparam int unsigned W = 13;

    logic         wr_clk = 1'b0, rd_clk = 1'b0;
    logic         rst_n = 1'b0, load_n = 1'b1, wr_en_n = 1'b1;
    logic         rd_en_a_n = 1'b1, rd_en_b_n = 1'b1;
    logic [8:0]   wr_byte = '0;
    logic [8:0]   rd_byte;
    logic [W-1:0] ae_ofs_wr, af_ofs_wr, ae_ofs_rd, af_ofs_rd;

    int  n_chk = 0, n_fail = 0;
    bit  done  = 1'b0;

    always #4 wr_clk = ~wr_clk;          // 125 MHz
    initial begin
        #3;
        forever #6 rd_clk = ~rd_clk;     // independent read clock
    end

    ofs_port #(.OFS_W(W)) dut (
        .wr_clk, .rd_clk, .rst_n, .load_n, .wr_en_n, .wr_byte,
        .rd_en_a_n, .rd_en_b_n, .rd_byte,
        .ae_ofs_wr, .af_ofs_wr, .ae_ofs_rd, .af_ofs_rd
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_step(input logic ld, input logic we, input logic [8:0] d);
        @(negedge wr_clk);
        load_n = ld; wr_en_n = we; wr_byte = d;
        @(negedge wr_clk);
        load_n = 1'b1; wr_en_n = 1'b1;
    endtask

    task automatic rd_step(input logic ld, input logic ea, input logic eb);
        @(negedge rd_clk);
        load_n = ld; rd_en_a_n = ea; rd_en_b_n = eb;
        @(negedge rd_clk);
        load_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        rst_n = 1'b0;
        repeat (6) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge rd_clk);
    endtask

    task automatic settle();
        repeat (20) @(negedge rd_clk);
    endtask

    // R1: reset values in both domains and on the readback bus
    task automatic t_reset();
        do_reset();
        check("R1 ae wr", 16'(ae_ofs_wr), 16'h7);
        check("R1 af wr", 16'(af_ofs_wr), 16'h7);
        check("R1 ae rd", 16'(ae_ofs_rd), 16'h7);
        check("R1 af rd", 16'(af_ofs_rd), 16'h7);
        check("R1 rd_byte", 16'(rd_byte), 16'h0);
    endtask

    // R2 / R4: four-step programming with ignored bit 8 and unused high bits
    task automatic t_program();
        wr_step(1'b0, 1'b0, 9'h1A5);
        check("R4 ae low byte, bit8 ignored", 16'(ae_ofs_wr), 16'h00A5);
        wr_step(1'b0, 1'b0, 9'h1FF);
        check("R2 ae high byte", 16'(ae_ofs_wr), 16'h1FA5);
        check("R2 af untouched", 16'(af_ofs_wr), 16'h0007);
        wr_step(1'b0, 1'b0, 9'h13C);
        check("R2 af low byte", 16'(af_ofs_wr), 16'h003C);
        wr_step(1'b0, 1'b0, 9'h0EA);
        check("R4 af high, bits above width ignored", 16'(af_ofs_wr), 16'h0A3C);
    endtask

    // R3 / R2: no-op edges, then the rotation wraps to the first step
    task automatic t_noop_wrap();
        wr_step(1'b0, 1'b1, 9'h055);
        check("R3 load without enable ae", 16'(ae_ofs_wr), 16'h1FA5);
        check("R3 load without enable af", 16'(af_ofs_wr), 16'h0A3C);
        wr_step(1'b1, 1'b0, 9'h0FF);
        check("R3 memory write ae", 16'(ae_ofs_wr), 16'h1FA5);
        check("R3 memory write af", 16'(af_ofs_wr), 16'h0A3C);
        wr_step(1'b0, 1'b0, 9'h111);
        check("R2 wrap to ae low", 16'(ae_ofs_wr), 16'h1F11);
    endtask

    // R9: read-domain copies catch up
    task automatic t_xfer();
        settle();
        check("R9 ae rd", 16'(ae_ofs_rd), 16'h1F11);
        check("R9 af rd", 16'(af_ofs_rd), 16'h0A3C);
    endtask

    // R5 / R6: four-step readback with zeroed unused bits, then wrap
    task automatic t_readback();
        rd_step(1'b0, 1'b0, 1'b0);
        check("R5 ae low", 16'(rd_byte), 16'h011);
        rd_step(1'b0, 1'b0, 1'b0);
        check("R6 ae high zero-filled", 16'(rd_byte), 16'h01F);
        rd_step(1'b0, 1'b0, 1'b0);
        check("R5 af low", 16'(rd_byte), 16'h03C);
        rd_step(1'b0, 1'b0, 1'b0);
        check("R6 af high zero-filled", 16'(rd_byte), 16'h00A);
        rd_step(1'b0, 1'b0, 1'b0);
        check("R5 read wrap", 16'(rd_byte), 16'h011);
    endtask

    // R7 / R8: disabled reads hold; writes do not move the read step
    task automatic t_hold_indep();
        rd_step(1'b0, 1'b1, 1'b0);
        check("R7 enable a high holds", 16'(rd_byte), 16'h011);
        rd_step(1'b0, 1'b0, 1'b1);
        check("R7 enable b high holds", 16'(rd_byte), 16'h011);
        rd_step(1'b1, 1'b0, 1'b0);
        check("R7 load high holds", 16'(rd_byte), 16'h011);
        wr_step(1'b0, 1'b0, 9'h003);
        check("R8 write step at ae high", 16'(ae_ofs_wr), 16'h0311);
        settle();
        check("R9 new ae in read domain", 16'(ae_ofs_rd), 16'h0311);
        rd_step(1'b0, 1'b0, 1'b0);
        check("R8 read step unmoved", 16'(rd_byte), 16'h003);
        rd_step(1'b0, 1'b0, 1'b0);
        check("R7 one step per read", 16'(rd_byte), 16'h03C);
    endtask

    // R1: reset from a busy state restarts both rotations
    task automatic t_rereset();
        do_reset();
        check("R1 ae wr after re-reset", 16'(ae_ofs_wr), 16'h7);
        check("R1 rd_byte after re-reset", 16'(rd_byte), 16'h0);
        rd_step(1'b0, 1'b0, 1'b0);
        check("R1 read step restarted", 16'(rd_byte), 16'h007);
        wr_step(1'b0, 1'b0, 9'h020);
        check("R1 write step restarted", 16'(ae_ofs_wr), 16'h0020);
        check("R1 af keeps default", 16'(af_ofs_wr), 16'h0007);
    endtask

    initial begin
        t_reset();
        t_program();
        t_noop_wrap();
        t_xfer();
        t_readback();
        t_hold_indep();
        t_rereset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule